// File: doc/BRIEF.md
# Mixed-Width Dual-Port Parity RAM

This block is a synchronous dual-port memory whose two ports may each present a different word width over one shared storage. The store holds 16384 data bits and 2048 parity bits. A parameter per port picks one of six aspect ratios. A port configured wide sees several consecutive narrow words glued together. A port configured narrow sees the pieces of a wide word one at a time. Every parity bit is bound to one data byte and follows that byte through any width change.

Both ports run from one shared clock. Each port has an enable, a write enable, an address, data and parity inputs, and registered data and parity outputs. A read returns its word one clock after it is issued. A write on a port is also visible on that port's own output in the same access. While its enable is low, a port's outputs keep their last value.

Top module: `mwram_dp`

## Requirements
- R1: The per-port parameter takes a total width of 1, 2, 4, 9, 18 or 36. This gives a data width of 1, 2, 4, 8, 16 or 32 bits, a parity width of 0, 0, 0, 1, 2 or 4 bits, and an address of 14, 13, 12, 11, 10 or 9 bits. Every address up to the port depth reaches its own storage.
- R2: A read issued with enable high on a clock edge appears on that port's data and parity outputs after that edge and stays until the next enabled edge.
- R3: While a port's enable is low, its data and parity outputs hold their value and its write enable has no effect.
- R4: An enabled write on a port puts the written data and parity on that same port's outputs one cycle later.
- R5: Data bit b at address A of a port with data width W is stored at global bit A*W+b. As a result, a wide read returns adjacent narrow words with the lowest address in the least significant bits.
- R6: A narrow read of data written wide returns the slice at global bits A*W to A*W+W-1.
- R7: Parity lane k at address A of a port with parity width P is stored at global parity bit A*P+k. Lane k guards data byte k, so a byte's parity follows it across widths.
- R8: Ports of width 1, 2 or 4 keep a 1-bit parity input that is ignored and a 1-bit parity output that reads 0.
- R9: While reset is asserted, all data and parity outputs are 0. Reset is applied asynchronously and released after two clock edges.
- R10: A read on one port in the same cycle as a write to the same bits on the other port returns the prior contents. Writes from both ports to disjoint bits in one cycle, even within one storage row, both take effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Shared clock for both ports |
| rst_n | input | 1 | Asynchronous active-low reset |
| a_en | input | 1 | Port A access enable |
| a_we | input | 1 | Port A write enable |
| a_addr | input | 14 - log2(data width A) | Port A word address |
| a_din | input | data width A | Port A write data |
| a_pin | input | max(parity width A, 1) | Port A write parity |
| a_dout | output | data width A | Port A read data |
| a_pout | output | max(parity width A, 1) | Port A read parity |
| b_en | input | 1 | Port B access enable |
| b_we | input | 1 | Port B write enable |
| b_addr | input | 14 - log2(data width B) | Port B word address |
| b_din | input | data width B | Port B write data |
| b_pin | input | max(parity width B, 1) | Port B write parity |
| b_dout | output | data width B | Port B read data |
| b_pout | output | max(parity width B, 1) | Port B read parity |

## Verification
Every result of this block is due exactly one clock after the edge that captures the access. This holds for read data, write-through data, held data and same-cycle cross-port reads. The bench drives each access on a falling edge and lets one rising edge pass. On that edge its bit-level model works out the expected word from the contents before this cycle's writes. The bench then compares on the following falling edge, so no register is left uncounted. Four width pairings are exercised, and every width is both written and read through its partner.

// File: rtl/mwram_pkg.sv
package mwram_pkg;

  localparam int ARRAY_BITS = 16384;
  localparam int WORD_DATA  = 32;
  localparam int WORD_PAR   = WORD_DATA / 8;
  localparam int WORD_BITS  = WORD_DATA + WORD_PAR;
  localparam int ROWS       = ARRAY_BITS / WORD_DATA;
  localparam int ROW_AW     = $clog2(ROWS);

  typedef logic [WORD_BITS-1:0] row_t;

  function automatic int data_w(input int tw);
    return (tw >= 9) ? (tw / 9) * 8 : tw;
  endfunction

  function automatic int par_w(input int tw);
    return tw - data_w(tw);
  endfunction

  function automatic int addr_w(input int tw);
    return $clog2(ARRAY_BITS / data_w(tw));
  endfunction

endpackage

// File: rtl/mwram_lane.sv
module mwram_lane import mwram_pkg::*; #(
  parameter  int TW  = 36,
  localparam int DW  = data_w(TW),
  localparam int PW  = par_w(TW),
  localparam int PWP = (PW > 0) ? PW : 1,
  localparam int AW  = addr_w(TW),
  localparam int SB  = AW - ROW_AW,
  localparam int SBW = (SB > 0) ? SB : 1
) (
  input  logic                wr,
  input  logic [AW-1:0]       addr,
  input  logic [DW-1:0]       din,
  input  logic [PWP-1:0]      pin,
  input  row_t                row_old,
  output logic [ROW_AW-1:0]   row,
  output row_t                wmask,
  output row_t                wdata,
  output logic [DW-1:0]       rd_d,
  output logic [PWP-1:0]      rd_p
);

  localparam logic [WORD_DATA:0] DT    = (33'd1 << DW) - 33'd1;
  localparam logic [WORD_DATA-1:0] DONES = DT[WORD_DATA-1:0];
  localparam logic [WORD_PAR:0]  PT    = (5'd1 << PW) - 5'd1;
  localparam logic [WORD_PAR-1:0] PONES = PT[WORD_PAR-1:0];

  logic [SBW-1:0]       slot;
  int                   dsh;
  int                   psh;
  logic [WORD_DATA-1:0] dmask;
  logic [WORD_DATA-1:0] dval;
  logic [WORD_PAR-1:0]  pmask;
  logic [WORD_PAR-1:0]  pval;
  logic [WORD_PAR-1:0]  pin4;
  row_t                 merged;

  generate
    if (SB == 0) begin : g_full_row
      assign row  = addr;
      assign slot = '0;
    end else begin : g_sub_row
      assign row  = addr[AW-1:SB];
      assign slot = addr[SB-1:0];
    end
  endgenerate

  always_comb begin
    dsh    = int'(slot) * DW;
    psh    = int'(slot) * PW;
    dmask  = DONES << dsh;
    pmask  = PONES << psh;
    pin4   = (PW > 0) ? WORD_PAR'(pin) : '0;
    dval   = WORD_DATA'(din) << dsh;
    pval   = pin4 << psh;
    wmask  = wr ? {pmask, dmask} : '0;
    wdata  = {pval, dval};
    merged = (row_old & ~wmask) | (wdata & wmask);
    rd_d   = DW'(merged[WORD_DATA-1:0] >> dsh);
    rd_p   = (PW > 0) ? PWP'(merged[WORD_BITS-1:WORD_DATA] >> psh) : '0;
  end

endmodule

// File: rtl/mwram_store.sv
module mwram_store import mwram_pkg::*; (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_a,
  input  logic [ROW_AW-1:0] row_a,
  input  row_t              mask_a,
  input  row_t              data_a,
  input  logic              wr_b,
  input  logic [ROW_AW-1:0] row_b,
  input  row_t              mask_b,
  input  row_t              data_b,
  output row_t              old_a,
  output row_t              old_b
);

  row_t mem [ROWS];
  row_t upd_a;
  row_t base_b;
  row_t upd_b;

  assign old_a = mem[row_a];
  assign old_b = mem[row_b];

  always_comb begin
    upd_a  = (mem[row_a] & ~mask_a) | (data_a & mask_a);
    base_b = (wr_a && (row_a == row_b)) ? upd_a : mem[row_b];
    upd_b  = (base_b & ~mask_b) | (data_b & mask_b);
  end

  always_ff @(posedge clk) begin
    if (wr_a) mem[row_a] <= upd_a;
    if (wr_b) mem[row_b] <= upd_b;
  end

  // R5: a lone port-A write leaves its masked bits in the addressed row
  p_lands_a_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_a && !(wr_b && row_b == row_a)) |=>
      (((mem[$past(row_a)] ^ $past(data_a)) & $past(mask_a)) == '0));

  // R10: disjoint writes from both ports in one cycle both take effect
  p_dual_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_a && wr_b && ((row_a != row_b) || ((mask_a & mask_b) == '0))) |=>
      ((((mem[$past(row_a)] ^ $past(data_a)) & $past(mask_a)) == '0) &&
       (((mem[$past(row_b)] ^ $past(data_b)) & $past(mask_b)) == '0)));

endmodule

// File: rtl/mwram_dp.sv
module mwram_dp import mwram_pkg::*; #(
  parameter  int WIDTH_A = 36,
  parameter  int WIDTH_B = 9,
  localparam int DWA = data_w(WIDTH_A),
  localparam int PWA = par_w(WIDTH_A),
  localparam int PPA = (PWA > 0) ? PWA : 1,
  localparam int AWA = addr_w(WIDTH_A),
  localparam int DWB = data_w(WIDTH_B),
  localparam int PWB = par_w(WIDTH_B),
  localparam int PPB = (PWB > 0) ? PWB : 1,
  localparam int AWB = addr_w(WIDTH_B)
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           a_en,
  input  logic           a_we,
  input  logic [AWA-1:0] a_addr,
  input  logic [DWA-1:0] a_din,
  input  logic [PPA-1:0] a_pin,
  output logic [DWA-1:0] a_dout,
  output logic [PPA-1:0] a_pout,
  input  logic           b_en,
  input  logic           b_we,
  input  logic [AWB-1:0] b_addr,
  input  logic [DWB-1:0] b_din,
  input  logic [PPB-1:0] b_pin,
  output logic [DWB-1:0] b_dout,
  output logic [PPB-1:0] b_pout
);

  logic [1:0]        rsync;
  logic              rst_q;
  logic              wr_a;
  logic              wr_b;
  logic [ROW_AW-1:0] row_a;
  logic [ROW_AW-1:0] row_b;
  row_t              mask_a;
  row_t              mask_b;
  row_t              data_a;
  row_t              data_b;
  row_t              old_a;
  row_t              old_b;
  logic [DWA-1:0]    rd_da;
  logic [PPA-1:0]    rd_pa;
  logic [DWB-1:0]    rd_db;
  logic [PPB-1:0]    rd_pb;
  logic [DWA-1:0]    a_dout_nx;
  logic [PPA-1:0]    a_pout_nx;
  logic [DWB-1:0]    b_dout_nx;
  logic [PPB-1:0]    b_pout_nx;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rsync <= '0;
    else        rsync <= {rsync[0], 1'b1};
  end
  assign rst_q = rsync[1];

  assign wr_a = a_en & a_we;
  assign wr_b = b_en & b_we;

  mwram_lane #(.TW(WIDTH_A)) u_lane_a (
    .wr(wr_a), .addr(a_addr), .din(a_din), .pin(a_pin), .row_old(old_a),
    .row(row_a), .wmask(mask_a), .wdata(data_a), .rd_d(rd_da), .rd_p(rd_pa)
  );

  mwram_lane #(.TW(WIDTH_B)) u_lane_b (
    .wr(wr_b), .addr(b_addr), .din(b_din), .pin(b_pin), .row_old(old_b),
    .row(row_b), .wmask(mask_b), .wdata(data_b), .rd_d(rd_db), .rd_p(rd_pb)
  );

  mwram_store u_store (
    .clk(clk), .rst_n(rst_q),
    .wr_a(wr_a), .row_a(row_a), .mask_a(mask_a), .data_a(data_a),
    .wr_b(wr_b), .row_b(row_b), .mask_b(mask_b), .data_b(data_b),
    .old_a(old_a), .old_b(old_b)
  );

  always_comb begin
    a_dout_nx = a_en ? rd_da : a_dout;
    a_pout_nx = a_en ? rd_pa : a_pout;
    b_dout_nx = b_en ? rd_db : b_dout;
    b_pout_nx = b_en ? rd_pb : b_pout;
  end

  always_ff @(posedge clk or negedge rst_q) begin
    if (!rst_q) begin
      a_dout <= '0;
      a_pout <= '0;
      b_dout <= '0;
      b_pout <= '0;
    end else begin
      a_dout <= a_dout_nx;
      a_pout <= a_pout_nx;
      b_dout <= b_dout_nx;
      b_pout <= b_pout_nx;
    end
  end

  // R3: an idle port keeps its outputs
  p_hold_a_r3: assert property (@(posedge clk) disable iff (!rst_q)
    !a_en |=> ($stable(a_dout) && $stable(a_pout)));
  p_hold_b_r3: assert property (@(posedge clk) disable iff (!rst_q)
    !b_en |=> ($stable(b_dout) && $stable(b_pout)));

  // R4: a write shows up on the writing port's output
  p_wfirst_a_r4: assert property (@(posedge clk) disable iff (!rst_q)
    (a_en && a_we) |=> (a_dout == $past(a_din)));
  p_wfirst_b_r4: assert property (@(posedge clk) disable iff (!rst_q)
    (b_en && b_we) |=> (b_dout == $past(b_din)));

  generate
    if (PWA > 0) begin : g_par_a
      // R7: parity written on port A comes back with its bytes
      p_par_wfirst_a_r7: assert property (@(posedge clk) disable iff (!rst_q)
        (a_en && a_we) |=> (a_pout == $past(a_pin)));
    end
    if (PWB > 0) begin : g_par_b
      p_par_wfirst_b_r7: assert property (@(posedge clk) disable iff (!rst_q)
        (b_en && b_we) |=> (b_pout == $past(b_pin)));
    end
  endgenerate

endmodule

// File: tb/sim_pair.sv
module sim_pair #(
  parameter int WA = 36,
  parameter int WB = 9
) (
  input  logic clk,
  input  logic rst_n,
  output int   n_chk,
  output int   n_bad,
  output logic fin
);

  function automatic int dwid(input int t);
    return (t >= 9) ? (t / 9) * 8 : t;
  endfunction
  function automatic int pwid(input int t);
    return t - dwid(t);
  endfunction

  localparam int DA = dwid(WA);
  localparam int PA = pwid(WA);
  localparam int QA = (PA > 0) ? PA : 1;
  localparam int NA = 16384 / DA;
  localparam int LA = $clog2(NA);
  localparam int DB = dwid(WB);
  localparam int PB = pwid(WB);
  localparam int QB = (PB > 0) ? PB : 1;
  localparam int NB = 16384 / DB;
  localparam int LB = $clog2(NB);

  logic          a_en, a_we, b_en, b_we;
  logic [LA-1:0] a_addr;
  logic [DA-1:0] a_din, a_dout;
  logic [QA-1:0] a_pin, a_pout;
  logic [LB-1:0] b_addr;
  logic [DB-1:0] b_din, b_dout;
  logic [QB-1:0] b_pin, b_pout;

  mwram_dp #(.WIDTH_A(WA), .WIDTH_B(WB)) u0 (
    .clk(clk), .rst_n(rst_n),
    .a_en(a_en), .a_we(a_we), .a_addr(a_addr), .a_din(a_din), .a_pin(a_pin),
    .a_dout(a_dout), .a_pout(a_pout),
    .b_en(b_en), .b_we(b_we), .b_addr(b_addr), .b_din(b_din), .b_pin(b_pin),
    .b_dout(b_dout), .b_pout(b_pout)
  );

  bit          ref_d [16384];
  bit          ref_p [2048];
  logic [31:0] ea_d, eb_d;
  logic [3:0]  ea_p, eb_p;
  string       tag_a, tag_b, ph;

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [31:0] got, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s WA=%0d WB=%0d %s got %h exp %h", req, WA, WB, what, got, exp);
    end
  endtask

  function automatic bit ovl(input int s0, input int w0, input int s1, input int w1);
    return (s0 < s1 + w1) && (s1 < s0 + w0);
  endfunction

  task automatic step(input bit ea, input bit wa, input int aa, input logic [31:0] da,
                      input logic [3:0] pa, input bit eb, input bit wb, input int ab,
                      input logic [31:0] db, input logic [3:0] pb);
    logic [31:0] rda, rdb;
    logic [3:0]  rpa, rpb;
    bit          xa, xb;
    a_en = ea; a_we = wa; a_addr = LA'(aa); a_din = DA'(da); a_pin = QA'(pa);
    b_en = eb; b_we = wb; b_addr = LB'(ab); b_din = DB'(db); b_pin = QB'(pb);
    @(posedge clk);
    rda = '0; rdb = '0; rpa = '0; rpb = '0;
    for (int b = 0; b < DA; b++) rda[b] = ref_d[aa*DA+b];
    for (int k = 0; k < PA; k++) rpa[k] = ref_p[aa*PA+k];
    for (int b = 0; b < DB; b++) rdb[b] = ref_d[ab*DB+b];
    for (int k = 0; k < PB; k++) rpb[k] = ref_p[ab*PB+k];
    xa = eb && wb && ovl(aa*DA, DA, ab*DB, DB);
    xb = ea && wa && ovl(aa*DA, DA, ab*DB, DB);
    if (ea && wa) begin
      for (int b = 0; b < DA; b++) begin rda[b] = da[b]; ref_d[aa*DA+b] = da[b]; end
      for (int k = 0; k < PA; k++) begin rpa[k] = pa[k]; ref_p[aa*PA+k] = pa[k]; end
    end
    if (eb && wb) begin
      for (int b = 0; b < DB; b++) begin rdb[b] = db[b]; ref_d[ab*DB+b] = db[b]; end
      for (int k = 0; k < PB; k++) begin rpb[k] = pb[k]; ref_p[ab*PB+k] = pb[k]; end
    end
    if (ea) begin ea_d = rda; ea_p = rpa; tag_a = wa ? "R4" : (xa ? "R10" : ph); end
    else tag_a = "R3";
    if (eb) begin eb_d = rdb; eb_p = rpb; tag_b = wb ? "R4" : (xb ? "R10" : ph); end
    else tag_b = "R3";
    @(negedge clk);
    chk(a_dout === ea_d[DA-1:0], tag_a, "A data", 32'(a_dout), ea_d);
    chk(a_pout === QA'(ea_p), (PA > 0) ? "R7" : "R8", "A parity", 32'(a_pout), 32'(ea_p));
    chk(b_dout === eb_d[DB-1:0], tag_b, "B data", 32'(b_dout), eb_d);
    chk(b_pout === QB'(eb_p), (PB > 0) ? "R7" : "R8", "B parity", 32'(b_pout), 32'(eb_p));
  endtask

  task automatic fill(input bit on_a);
    ph = "R4";
    for (int i = 0; i < (on_a ? NA : NB); i++) begin
      if (on_a) step(1, 1, i, $urandom, 4'($urandom), 0, 0, 0, 0, 0);
      else      step(0, 0, 0, 0, 0, 1, 1, i, $urandom, 4'($urandom));
    end
  endtask

  task automatic sweep(input bit on_a, input string t);
    ph = t;
    for (int i = 0; i < (on_a ? NA : NB); i++) begin
      if (on_a) step(1, 0, i, $urandom, 4'($urandom), 0, 1, 0, 0, 0);
      else      step(0, 1, 0, 0, 0, 1, 0, i, $urandom, 4'($urandom));
    end
  endtask

  initial begin
    n_chk = 0; n_bad = 0; fin = 1'b0;
    ea_d = '0; eb_d = '0; ea_p = '0; eb_p = '0;
    a_en = 0; a_we = 0; a_addr = '0; a_din = '0; a_pin = '0;
    b_en = 0; b_we = 0; b_addr = '0; b_din = '0; b_pin = '0;
    @(negedge clk);
    chk(a_dout === '0 && a_pout === '0, "R9", "A reset", 32'(a_dout), 0);
    chk(b_dout === '0 && b_pout === '0, "R9", "B reset", 32'(b_dout), 0);
    wait (rst_n === 1'b1);
    repeat (3) @(negedge clk);
    chk(a_dout === '0 && b_dout === '0, "R9", "after release", 32'(a_dout), 0);
    if (WA >= WB) begin
      fill(1); sweep(0, (DB < DA) ? "R1 R6" : "R1 R5");
      fill(0); sweep(1, (DA > DB) ? "R1 R5" : "R1 R6");
    end else begin
      fill(0); sweep(1, (DA < DB) ? "R1 R6" : "R1 R5");
      fill(1); sweep(0, (DB > DA) ? "R1 R5" : "R1 R6");
    end
    ph = "R2";
    for (int n = 0; n < 3000; n++) begin
      bit ea = 1'($urandom), wa = 1'($urandom), eb = 1'($urandom), wb = 1'($urandom);
      int aa = $urandom_range(NA - 1);
      int ab = $urandom_range(NB - 1);
      if (ea && wa && eb && wb && ovl(aa*DA, DA, ab*DB, DB)) wb = 0;
      step(ea, wa, aa, $urandom, 4'($urandom), eb, wb, ab, $urandom, 4'($urandom));
    end
    fin = 1'b1;
  end

endmodule

// File: tb/sim_mwram_dp.sv
`timescale 1ns/1ps
module sim_mwram_dp;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  int   c0, c1, c2, c3, b0, b1, b2, b3;
  logic f0, f1, f2, f3;
  bit   timed_out = 1'b0;

  always #2.5 clk = ~clk;

  initial begin
    #22 rst_n = 1'b1;
  end

  sim_pair #(.WA(36), .WB(9))  g0 (.clk(clk), .rst_n(rst_n), .n_chk(c0), .n_bad(b0), .fin(f0));
  sim_pair #(.WA(18), .WB(1))  g1 (.clk(clk), .rst_n(rst_n), .n_chk(c1), .n_bad(b1), .fin(f1));
  sim_pair #(.WA(4),  .WB(36)) g2 (.clk(clk), .rst_n(rst_n), .n_chk(c2), .n_bad(b2), .fin(f2));
  sim_pair #(.WA(2),  .WB(18)) g3 (.clk(clk), .rst_n(rst_n), .n_chk(c3), .n_bad(b3), .fin(f3));

  initial begin
    int tot, bad;
    fork
      begin
        wait (f0 === 1'b1 && f1 === 1'b1 && f2 === 1'b1 && f3 === 1'b1);
      end
      begin
        repeat (150000) @(posedge clk);
        timed_out = 1'b1;
      end
    join_any
    disable fork;
    tot = c0 + c1 + c2 + c3;
    bad = b0 + b1 + b2 + b3;
    if (timed_out) begin
      tot++;
      bad++;
      $display("FAIL R2 watchdog expired got 0 exp 1");
    end
    $display("  test done: total=%0d bad=%0d", tot, bad);
    $finish;
  end

endmodule